// File: doc/BRIEF.md
# Linked-List DMA Descriptor Loader

This block is the control half of one scatter/gather DMA channel. Software preloads the first transfer descriptor through a small register write port. Each descriptor has four words: source address, destination address, link to the next descriptor, and a control word. Software then sets the enable bit in the configuration register. From that point the channel works alone. It hands each segment's addresses and count to an external data mover through a start/done handshake. It then reads the next four-word descriptor from memory over a word-read request/acknowledge port, and repeats until the chain ends or a fetch fails.

Each descriptor can ask for a terminal-count interrupt at the end of its own segment. Software can therefore track progress through a long chain, not only its completion. A link of zero ends the chain. An error response on a descriptor read abandons the chain and raises an error pulse. In both cases the channel drops its enable bit and goes idle.

Top module: `dma_ll_channel`

## Requirements
- R1: While reset is applied, and in the cycles after its release before any enable write, `busy`, `rd_req`, `mv_start`, `tc_irq` and `err_irq` are all low.
- R2: A software write uses `sw_sel` to pick a register: 0 = source address, 1 = destination address, 2 = next-descriptor link, 3 = control, 4 = configuration, where bit 0 is the enable bit. A write is taken only while `busy` is low. A write made while `busy` is high changes nothing, so a later segment launched from the preloaded registers still shows the old value on `mv_src`.
- R3: Writing the configuration register with bit 0 set raises `busy` in the next cycle and starts the first segment. Writing it with bit 0 clear starts nothing, and `busy` stays low.
- R4: A descriptor fetch raises `rd_req` with `rd_addr` at link+0, +4, +8 and +12 in that order. Each address is held until `rd_ack`. The four words land in source, destination, link and control, in that order.
- R5: A segment with a non-zero count is launched by a one-cycle `mv_start` pulse. The pulse carries `mv_src`, `mv_dst` and `mv_count` = control bits [11:0]. It comes only after all four words of the descriptor have arrived, and never in a cycle with `rd_req` high. The segment ends in the cycle after `mv_done`.
- R6: `tc_irq` pulses for exactly one cycle at the end of every segment whose control bit 31 is set, and stays low for segments where that bit is clear.
- R7: A segment whose count field is zero issues no `mv_start` and ends in the cycle after its launch.
- R8: At the end of a segment whose link is zero, the channel clears its enable bit and drops `busy` in the following cycle, with no further fetch.
- R9: An acknowledge that carries `rd_err` during a fetch pulses `err_irq` in that same cycle. It clears the enable bit and drops `busy` in the next cycle, with no further `rd_req` or `mv_start`.
- R10: `busy` stays high from the cycle after the enable write until the chain finishes or aborts. While it is low, `rd_req`, `mv_start` and `tc_irq` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sw_we | input | 1 | Software register write strobe |
| sw_sel | input | 3 | Register select for a software write |
| sw_data | input | W | Software write data |
| rd_req | output | 1 | Descriptor word read request |
| rd_addr | output | W | Descriptor word byte address |
| rd_ack | input | 1 | Read acknowledge; data or error valid |
| rd_data | input | W | Read data |
| rd_err | input | 1 | Error response, qualified by `rd_ack` |
| mv_start | output | 1 | One-cycle segment start to the data mover |
| mv_src | output | W | Segment source address |
| mv_dst | output | W | Segment destination address |
| mv_count | output | CNT_W | Segment transfer count |
| mv_done | input | 1 | Data mover finished the segment |
| tc_irq | output | 1 | Per-segment terminal-count interrupt pulse |
| err_irq | output | 1 | Descriptor fetch error pulse |
| busy | output | 1 | Channel active |

## Verification
Two pairs of events can meet in one cycle. The first is the acknowledge that completes a descriptor fetch, which meets the software write gate: a write is issued right after the enable while busy is already high. The reference model must show the register unchanged once the chain has finished. The second is the error acknowledge, which meets the enable clear. A fault is injected on the third word of a fetch, and the bench checks that the error pulse, the enable drop and the suppression of any further start all agree with the model cycle by cycle. Zero-count segments and zero links that come straight after a multi-cycle fetch with varying acknowledge latency exercise the segment-end decision with no idle cycle between.

// File: rtl/dma_ll_pkg.sv
package dma_ll_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LAUNCH,
    ST_MOVE,
    ST_SEGEND,
    ST_FETCH
  } ch_state_t;

  localparam int unsigned DESC_WORDS = 4;
  localparam int unsigned SEL_W      = 3;

  localparam logic [SEL_W-1:0] SEL_SRC = 3'd0;
  localparam logic [SEL_W-1:0] SEL_DST = 3'd1;
  localparam logic [SEL_W-1:0] SEL_NXT = 3'd2;
  localparam logic [SEL_W-1:0] SEL_CTL = 3'd3;
  localparam logic [SEL_W-1:0] SEL_CFG = 3'd4;
endpackage

// File: rtl/dma_ll_rst_sync.sv
module dma_ll_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sr_q;
  logic [1:0] sr_d;

  always_comb begin
    sr_d = {sr_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign rst_sync_n = sr_q[1];
endmodule

// File: rtl/dma_ll_regs.sv
module dma_ll_regs
  import dma_ll_pkg::*;
#(
  parameter int unsigned W = 32,
  localparam int unsigned IDXW = $clog2(DESC_WORDS)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            sw_we,
  input  logic [SEL_W-1:0]                sw_sel,
  input  logic [W-1:0]                    sw_data,
  input  logic                            sw_allow,
  input  logic                            ld_we,
  input  logic [IDXW-1:0]                 ld_idx,
  input  logic [W-1:0]                    ld_data,
  input  logic                            clr_en,
  output logic [DESC_WORDS-1:0][W-1:0]    desc_o,
  output logic                            en_o
);
  logic sw_take;
  assign sw_take = sw_we & sw_allow;

  for (genvar g = 0; g < DESC_WORDS; g++) begin : g_word
    logic         wr_sw;
    logic         wr_ld;
    logic         word_we;
    logic [W-1:0] word_d;
    logic [W-1:0] word_q;

    always_comb begin
      wr_sw   = sw_take & (sw_sel == SEL_W'(g));
      wr_ld   = ld_we & (ld_idx == IDXW'(g));
      word_we = wr_sw | wr_ld;
      word_d  = wr_ld ? ld_data : sw_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       word_q <= '0;
      else if (word_we) word_q <= word_d;
    end

    assign desc_o[g] = word_q;
  end

  logic en_q;
  logic en_d;
  logic en_we;
  logic cfg_wr;

  always_comb begin
    cfg_wr = sw_take & (sw_sel == SEL_CFG);
    en_we  = cfg_wr | clr_en;
    en_d   = cfg_wr ? sw_data[0] : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= 1'b0;
    else if (en_we) en_q <= en_d;
  end

  assign en_o = en_q;
endmodule

// File: rtl/dma_ll_fetch.sv
module dma_ll_fetch
  import dma_ll_pkg::*;
#(
  parameter int unsigned W = 32,
  localparam int unsigned IDXW = $clog2(DESC_WORDS),
  localparam int unsigned BSH  = $clog2(W / 8)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            go,
  input  logic [W-1:0]    base,
  output logic            rd_req,
  output logic [W-1:0]    rd_addr,
  input  logic            rd_ack,
  input  logic            rd_err,
  output logic            ld_we,
  output logic [IDXW-1:0] ld_idx,
  output logic            last,
  output logic            err
);
  localparam logic [IDXW-1:0] LAST_IDX = IDXW'(DESC_WORDS - 1);

  logic            act_q, act_d;
  logic [IDXW-1:0] idx_q, idx_d;
  logic [W-1:0]    base_q;
  logic            step;

  always_comb begin
    step  = act_q & rd_ack;
    act_d = act_q;
    idx_d = idx_q;
    if (go) begin
      act_d = 1'b1;
      idx_d = '0;
    end else if (step) begin
      if (rd_err || idx_q == LAST_IDX) act_d = 1'b0;
      else                              idx_d = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      idx_q <= '0;
    end else begin
      act_q <= act_d;
      idx_q <= idx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  base_q <= '0;
    else if (go) base_q <= base;
  end

  assign rd_req  = act_q;
  assign rd_addr = base_q + (W'(idx_q) << BSH);
  assign ld_we   = step & ~rd_err;
  assign ld_idx  = idx_q;
  assign last    = ld_we & (idx_q == LAST_IDX);
  assign err     = step & rd_err;
endmodule

// File: rtl/dma_ll_ctrl.sv
module dma_ll_ctrl
  import dma_ll_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic cnt_zero,
  input  logic nxt_zero,
  input  logic irq_req,
  input  logic mv_done,
  input  logic fetch_last,
  input  logic fetch_err,
  output logic mv_start,
  output logic tc_irq,
  output logic err_irq,
  output logic clr_en,
  output logic fetch_go,
  output logic in_idle
);
  ch_state_t st_q, st_d;

  always_comb begin
    st_d     = st_q;
    mv_start = 1'b0;
    tc_irq   = 1'b0;
    err_irq  = 1'b0;
    clr_en   = 1'b0;
    fetch_go = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (en) st_d = ST_LAUNCH;
      end
      ST_LAUNCH: begin
        if (cnt_zero) begin
          st_d = ST_SEGEND;
        end else begin
          mv_start = 1'b1;
          st_d     = ST_MOVE;
        end
      end
      ST_MOVE: begin
        if (mv_done) st_d = ST_SEGEND;
      end
      ST_SEGEND: begin
        tc_irq = irq_req;
        if (nxt_zero) begin
          clr_en = 1'b1;
          st_d   = ST_IDLE;
        end else begin
          fetch_go = 1'b1;
          st_d     = ST_FETCH;
        end
      end
      ST_FETCH: begin
        if (fetch_err) begin
          err_irq = 1'b1;
          clr_en  = 1'b1;
          st_d    = ST_IDLE;
        end else if (fetch_last) begin
          st_d = ST_LAUNCH;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign in_idle = (st_q == ST_IDLE);
endmodule

// File: rtl/dma_ll_channel.sv
module dma_ll_channel
  import dma_ll_pkg::*;
#(
  parameter int unsigned W       = 32,
  parameter int unsigned CNT_W   = 12,
  parameter int unsigned IRQ_BIT = 31
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_we,
  input  logic [SEL_W-1:0] sw_sel,
  input  logic [W-1:0]     sw_data,
  output logic             rd_req,
  output logic [W-1:0]     rd_addr,
  input  logic             rd_ack,
  input  logic [W-1:0]     rd_data,
  input  logic             rd_err,
  output logic             mv_start,
  output logic [W-1:0]     mv_src,
  output logic [W-1:0]     mv_dst,
  output logic [CNT_W-1:0] mv_count,
  input  logic             mv_done,
  output logic             tc_irq,
  output logic             err_irq,
  output logic             busy
);
  localparam int unsigned IDXW = $clog2(DESC_WORDS);

  logic                         rst_s_n;
  logic [DESC_WORDS-1:0][W-1:0] desc;
  logic                         en;
  logic                         ld_we;
  logic [IDXW-1:0]              ld_idx;
  logic                         f_last;
  logic                         f_err;
  logic                         clr_en;
  logic                         f_go;
  logic                         in_idle;
  logic [W-1:0]                 ctl_word;

  dma_ll_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  dma_ll_regs #(.W(W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .sw_we    (sw_we),
    .sw_sel   (sw_sel),
    .sw_data  (sw_data),
    .sw_allow (~busy),
    .ld_we    (ld_we),
    .ld_idx   (ld_idx),
    .ld_data  (rd_data),
    .clr_en   (clr_en),
    .desc_o   (desc),
    .en_o     (en)
  );

  dma_ll_fetch #(.W(W)) u_fetch (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .go      (f_go),
    .base    (desc[SEL_NXT]),
    .rd_req  (rd_req),
    .rd_addr (rd_addr),
    .rd_ack  (rd_ack),
    .rd_err  (rd_err),
    .ld_we   (ld_we),
    .ld_idx  (ld_idx),
    .last    (f_last),
    .err     (f_err)
  );

  assign ctl_word = desc[SEL_CTL];

  dma_ll_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .en         (en),
    .cnt_zero   (ctl_word[CNT_W-1:0] == '0),
    .nxt_zero   (desc[SEL_NXT] == '0),
    .irq_req    (ctl_word[IRQ_BIT]),
    .mv_done    (mv_done),
    .fetch_last (f_last),
    .fetch_err  (f_err),
    .mv_start   (mv_start),
    .tc_irq     (tc_irq),
    .err_irq    (err_irq),
    .clr_en     (clr_en),
    .fetch_go   (f_go),
    .in_idle    (in_idle)
  );

  assign mv_src   = desc[SEL_SRC];
  assign mv_dst   = desc[SEL_DST];
  assign mv_count = ctl_word[CNT_W-1:0];
  assign busy     = en | ~in_idle;
endmodule

// File: rtl/dma_ll_channel_chk.sv
module dma_ll_channel_chk #(
  parameter int unsigned W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         rd_req,
  input logic [W-1:0] rd_addr,
  input logic         rd_ack,
  input logic         rd_err,
  input logic         mv_start,
  input logic         tc_irq,
  input logic         err_irq,
  input logic         busy
);
  localparam logic [W-1:0] STEP = W'(W / 8);

  p_hold_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr)));

  p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_ack && !rd_err) |=> (!rd_req || rd_addr == $past(rd_addr) + STEP));

  p_start_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mv_start |=> !mv_start);

  p_no_overlap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req && mv_start));

  p_tc_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tc_irq |=> !tc_irq);

  p_err_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq |=> (!busy && !rd_req && !mv_start));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!rd_req && !mv_start && !tc_irq));
endmodule

bind dma_ll_channel dma_ll_channel_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_s_n),
  .rd_req   (rd_req),
  .rd_addr  (rd_addr),
  .rd_ack   (rd_ack),
  .rd_err   (rd_err),
  .mv_start (mv_start),
  .tc_irq   (tc_irq),
  .err_irq  (err_irq),
  .busy     (busy)
);

// File: tb/dma_ll_channel_test.sv
module dma_ll_channel_test;
  localparam int CLK_PERIOD = 10;
  localparam int PH_IDLE = 0, PH_LAUNCH = 1, PH_MOVE = 2, PH_SEGEND = 3, PH_FETCH = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        sw_we;
  logic [2:0]  sw_sel;
  logic [31:0] sw_data;
  logic        rd_req;
  logic [31:0] rd_addr;
  logic        rd_ack;
  logic [31:0] rd_data;
  logic        rd_err;
  logic        mv_start;
  logic [31:0] mv_src;
  logic [31:0] mv_dst;
  logic [11:0] mv_count;
  logic        mv_done;
  logic        tc_irq;
  logic        err_irq;
  logic        busy;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dma_ll_channel uut (
    .clk(clk), .rst_n(rst_n), .sw_we(sw_we), .sw_sel(sw_sel), .sw_data(sw_data),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data), .rd_err(rd_err),
    .mv_start(mv_start), .mv_src(mv_src), .mv_dst(mv_dst), .mv_count(mv_count),
    .mv_done(mv_done), .tc_irq(tc_irq), .err_irq(err_irq), .busy(busy)
  );

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  logic [31:0] mem [int];
  logic [31:0] err_addr = 32'hFFFF_FFFC;

  // behavioural reference state
  int          m_phase;
  logic [31:0] m_reg [4];
  bit          m_en;
  bit          m_fact;
  int          m_fidx;
  logic [31:0] m_fbase;
  int          m_wait;
  int          m_mvleft;

  int          n_start, n_tc, n_err;
  logic [31:0] last_src;

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h (t=%0t)", tag, what, act, exp, $time);
    end
  endtask

  function automatic int lat(input logic [31:0] a);
    return int'((a >> 2) % 3);
  endfunction

  function automatic logic [31:0] mem_rd(input logic [31:0] a);
    if (mem.exists(int'(a))) return mem[int'(a)];
    return 32'h0;
  endfunction

  task automatic tick(input bit we = 1'b0, input int sel = 0, input logic [31:0] data = 32'h0);
    bit          e_busy, e_req, e_start, e_tc, e_err, ack, aerr;
    logic [31:0] e_addr;
    int          old_phase, old_fidx;
    bit          old_en;
    e_busy = m_en || (m_phase != PH_IDLE);
    e_req  = m_fact;
    e_addr = m_fbase + 32'(4 * m_fidx);
    ack    = m_fact && (m_wait == 0);
    aerr   = ack && (e_addr == err_addr);
    sw_we   = we;
    sw_sel  = 3'(sel);
    sw_data = data;
    rd_ack  = ack;
    rd_err  = aerr;
    rd_data = ack ? mem_rd(e_addr) : 32'h0;
    mv_done = (m_phase == PH_MOVE) && (m_mvleft == 1);
    e_start = (m_phase == PH_LAUNCH) && (m_reg[3][11:0] != 12'h0);
    e_tc    = (m_phase == PH_SEGEND) && m_reg[3][31];
    e_err   = (m_phase == PH_FETCH) && aerr;
    #1;
    check("R10", "busy", 32'(busy), 32'(e_busy));
    check("R4", "rd_req", 32'(rd_req), 32'(e_req));
    if (e_req) check("R4", "rd_addr", rd_addr, e_addr);
    check("R5", "mv_start", 32'(mv_start), 32'(e_start));
    if (e_start) begin
      check("R5", "mv_src", mv_src, m_reg[0]);
      check("R5", "mv_dst", mv_dst, m_reg[1]);
      check("R5", "mv_count", 32'(mv_count), 32'(m_reg[3][11:0]));
    end
    check("R6", "tc_irq", 32'(tc_irq), 32'(e_tc));
    check("R9", "err_irq", 32'(err_irq), 32'(e_err));
    if (mv_start) begin n_start++; last_src = mv_src; end
    if (tc_irq) n_tc++;
    if (err_irq) n_err++;
    // advance the reference by one clock
    old_phase = m_phase;
    old_fidx  = m_fidx;
    old_en    = m_en;
    if (m_fact) begin
      if (ack) begin
        if (aerr) m_fact = 1'b0;
        else begin
          m_reg[m_fidx] = rd_data;
          if (m_fidx == 3) m_fact = 1'b0;
          else begin m_fidx++; m_wait = lat(m_fbase + 32'(4 * m_fidx)); end
        end
      end else m_wait--;
    end
    if (we && !e_busy) begin
      if (sel < 4) m_reg[sel] = data;
      else if (sel == 4) m_en = data[0];
    end
    case (old_phase)
      PH_IDLE:   if (old_en) m_phase = PH_LAUNCH;
      PH_LAUNCH: begin
        if (m_reg[3][11:0] == 12'h0) m_phase = PH_SEGEND;
        else begin m_mvleft = int'(m_reg[3][11:0]); m_phase = PH_MOVE; end
      end
      PH_MOVE: begin
        if (m_mvleft == 1) m_phase = PH_SEGEND;
        else m_mvleft--;
      end
      PH_SEGEND: begin
        if (m_reg[2] == 32'h0) begin m_en = 1'b0; m_phase = PH_IDLE; end
        else begin
          m_fact = 1'b1; m_fidx = 0; m_fbase = m_reg[2]; m_wait = lat(m_reg[2]);
          m_phase = PH_FETCH;
        end
      end
      PH_FETCH: begin
        if (aerr) begin m_en = 1'b0; m_phase = PH_IDLE; end
        else if (ack && old_fidx == 3) m_phase = PH_LAUNCH;
      end
      default: m_phase = PH_IDLE;
    endcase
    @(negedge clk);
  endtask

  task automatic run_idle();
    int guard = 0;
    while ((m_en || m_phase != PH_IDLE) && guard < 2000) begin
      tick();
      guard++;
    end
    tick();
  endtask

  task automatic clr_counts();
    n_start = 0; n_tc = 0; n_err = 0;
  endtask

  task automatic put_desc(input int a, input logic [31:0] s, input logic [31:0] d,
                          input logic [31:0] n, input logic [31:0] c);
    mem[a] = s; mem[a + 4] = d; mem[a + 8] = n; mem[a + 12] = c;
  endtask

  initial begin
    int wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 20000) begin
        failures++;
        $display("FAIL R10 watchdog actual=%0d expected=<20000", wd);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0; sw_we = 1'b0; sw_sel = '0; sw_data = '0;
    rd_ack = 1'b0; rd_data = '0; rd_err = 1'b0; mv_done = 1'b0;
    m_phase = PH_IDLE; m_en = 1'b0; m_fact = 1'b0; m_fidx = 0; m_fbase = '0;
    m_wait = 0; m_mvleft = 0;
    for (int i = 0; i < 4; i++) m_reg[i] = '0;
    last_src = '0;
    clr_counts();
    repeat (3) @(negedge clk);
    // R1: quiet during reset
    check("R1", "busy in reset", 32'(busy), 0);
    check("R1", "rd_req in reset", 32'(rd_req), 0);
    check("R1", "mv_start in reset", 32'(mv_start), 0);
    check("R1", "irqs in reset", 32'({tc_irq, err_irq}), 0);
    rst_n = 1'b1;
    repeat (4) tick();

    // single segment with interrupt, link zero ends the chain (R3 R6 R8)
    tick(1, 0, 32'h0000_1000);
    tick(1, 1, 32'h0000_2000);
    tick(1, 2, 32'h0);
    tick(1, 3, 32'h8000_0005);
    clr_counts();
    tick(1, 4, 32'h1);
    check("R3", "busy after enable", 32'(busy), 1);
    run_idle();
    check("R5", "starts single", n_start, 1);
    check("R6", "tc single", n_tc, 1);
    check("R8", "busy after last", 32'(busy), 0);

    // three linked descriptors plus a write while busy (R2 R4 R7)
    put_desc(32'h100, 32'h1100, 32'h2100, 32'h200, 32'h0000_0003);
    put_desc(32'h200, 32'h1200, 32'h2200, 32'h300, 32'h8000_0000);
    put_desc(32'h300, 32'h1300, 32'h2300, 32'h0,   32'h8000_0002);
    tick(1, 0, 32'h0000_1010);
    tick(1, 1, 32'h0000_2010);
    tick(1, 2, 32'h0000_0100);
    tick(1, 3, 32'h8000_0004);
    clr_counts();
    tick(1, 4, 32'h1);
    tick(1, 0, 32'hDEAD_BEEF);
    run_idle();
    check("R4", "starts chain", n_start, 3);
    check("R6", "tc chain", n_tc, 3);
    check("R7", "zero-count segment tc without start", n_tc - n_start, 0);

    // R2: enable without rewriting source; loaded source must survive
    tick(1, 3, 32'h0000_0001);
    clr_counts();
    tick(1, 4, 32'h1);
    run_idle();
    check("R2", "source after ignored write", last_src, 32'h0000_1300);
    check("R6", "tc clear bit", n_tc, 0);

    // R3: enable bit clear starts nothing
    tick(1, 4, 32'h0);
    repeat (5) tick();
    check("R3", "no start with bit0 clear", 32'(busy), 0);

    // fetch error on third word (R9)
    put_desc(32'h400, 32'h1400, 32'h2400, 32'h0, 32'h0000_0002);
    err_addr = 32'h408;
    tick(1, 2, 32'h0000_0400);
    tick(1, 3, 32'h0000_0001);
    clr_counts();
    tick(1, 4, 32'h1);
    run_idle();
    check("R9", "err pulses", n_err, 1);
    check("R9", "starts before abort", n_start, 1);
    check("R9", "busy after abort", 32'(busy), 0);
    err_addr = 32'hFFFF_FFFC;

    // zero count, no interrupt, link zero (R7)
    tick(1, 2, 32'h0);
    tick(1, 3, 32'h0);
    clr_counts();
    tick(1, 4, 32'h1);
    run_idle();
    check("R7", "zero count starts", n_start, 0);
    check("R7", "zero count tc", n_tc, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule